// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single 36-bit words between two ports that run on unrelated clocks. It sits next to a FIFO datapath. Port A loads mailbox 1 and port B takes it. Port B loads mailbox 2 and port A takes it. Each mailbox has an active-low full flag in the writer's clock domain. A write pulls the flag low. The flag rises again only after the reader has taken the word and that event has been carried back across the clock boundary. Each reader also sees a "mail ready" indication in its own domain.

Each port has a write/read select and a mailbox select. Port A writes when its select is high. Port B writes when its select is low. In read mode, the port's read data is one of two sources:

- the mailbox coming from the other port, when the mailbox select is high;
- the port's FIFO output-register word, when the mailbox select is low. The FIFO storage itself is outside the block, and its output register appears here as an input.

An output enable tells the pads when to drive the port's bus. Each mailbox is reset together with the FIFO that travels in the same direction.

Write and read events cross between the domains as toggles through two-flop synchronizers. A mailbox word stays frozen while its flag is low, so the reader samples it directly with no data synchronizer.

Writer state machine, per mailbox, in the writer clock:

| State | Meaning | Transition out |
|---|---|---|
| `W_EMPTY` | Flag high | `W_EMPTY -> W_FULL` on an accepted write, which loads the word and flips the write toggle |
| `W_FULL` | Flag low | `W_FULL -> W_EMPTY` when the synchronized read toggle equals the write toggle |

Reader state machine, per mailbox, in the reader clock:

| State | Meaning | Transition out |
|---|---|---|
| `R_IDLE` | No mail waiting | `R_IDLE -> R_HOLD` when the synchronized write toggle differs from the read toggle |
| `R_HOLD` | Mail waiting (ready high) | `R_HOLD -> R_IDLE` on a mailbox read, which flips the read toggle |

Top module: `mbx_pair`

## Requirements
- R1: A port A clock edge with `a_wr_sel`=1 and `a_mbx_sel`=1 loads `a_wdata` into mailbox 1, and `a_mail_full_n` is 0 after that edge. A port B clock edge with `b_wr_sel`=0 and `b_mbx_sel`=1 does the same for mailbox 2 and `b_mail_full_n`. A write with the mailbox select at 0 leaves the mailbox untouched.
- R2: While a port's full flag is 0, further writes to its mailbox are ignored, and the reader later receives the first word.
- R3: After a mailbox write, the reader's ready output (`b_mail_ready` for mailbox 1, `a_mail_ready` for mailbox 2) rises within a few reader clocks. A reader edge with mailbox read selected while ready is high drops ready after that edge. The writer's full flag then returns to 1 within a few writer clocks.
- R4: A mailbox read while the reader's ready is 0 has no effect: it neither raises the writer's flag nor consumes a later write.
- R5: Port A's bus is driven (`a_oe`=1) only while `a_wr_sel`=0. Port B's bus is driven (`b_oe`=1) only while `b_wr_sel`=1.
- R6: In read mode, `a_rdata` is mailbox 2 when `a_mbx_sel`=1 and `a_fifo_q` when it is 0. `b_rdata` is mailbox 1 when `b_mbx_sel`=1 and `b_fifo_q` when it is 0.
- R7: `fifo1_rst_n`=0 forces `a_mail_full_n` to 1 and `b_mail_ready` to 0. `fifo2_rst_n`=0 does the same to `b_mail_full_n` and `a_mail_ready`. Neither reset disturbs the other mailbox.
- R8: Under unrelated clock periods and random spacing, every word written to a mailbox is read exactly once and in order: none lost, none duplicated, none stale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| fifo1_rst_n | input | 1 | Active-low reset of the A-to-B direction (mailbox 1) |
| fifo2_rst_n | input | 1 | Active-low reset of the B-to-A direction (mailbox 2) |
| a_wr_sel | input | 1 | Port A direction, 1 = write |
| a_mbx_sel | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Port A write data |
| a_fifo_q | input | 36 | B-to-A FIFO output-register word |
| a_rdata | output | 36 | Port A read data |
| a_oe | output | 1 | Port A bus drive enable |
| a_mail_full_n | output | 1 | Mailbox 1 full flag, active low, clk_a domain |
| a_mail_ready | output | 1 | Mailbox 2 holds unread mail, clk_a domain |
| b_wr_sel | input | 1 | Port B direction, 0 = write |
| b_mbx_sel | input | 1 | Port B mailbox select |
| b_wdata | input | 36 | Port B write data |
| b_fifo_q | input | 36 | A-to-B FIFO output-register word |
| b_rdata | output | 36 | Port B read data |
| b_oe | output | 1 | Port B bus drive enable |
| b_mail_full_n | output | 1 | Mailbox 2 full flag, active low, clk_b domain |
| b_mail_ready | output | 1 | Mailbox 1 holds unread mail, clk_b domain |

## Verification
The bench writes into a full mailbox. A design that accepted that write would deliver the second word instead of the first. It issues reads while no mail is waiting. A design that acknowledged them would raise the writer's flag early or swallow the next word. It resets each FIFO direction with mail pending, which exposes a flag stuck low or a reset that crosses into the wrong mailbox. Random traffic at unrelated clock periods catches a broken handshake: repeated words mean ready was not cleared on a read, a hang means a lost toggle, and a word mismatch means stale data.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int MBX_W = 36;

    typedef enum logic {
        W_EMPTY = 1'b0,
        W_FULL  = 1'b1
    } wr_state_t;

    typedef enum logic {
        R_IDLE = 1'b0,
        R_HOLD = 1'b1
    } rd_state_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int W          = MBX_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wdata,
    output logic         full_n,
    input  logic         rd_req,
    output logic         ready,
    output logic [W-1:0] rdata
);
    // writer domain
    wr_state_t    w_state, w_next;
    logic         w_tog;
    logic         w_load;
    logic [W-1:0] data_q;
    logic         ack_sync;

    // reader domain
    rd_state_t    r_state, r_next;
    logic         r_tog;
    logic         r_ack;
    logic         put_sync;

    mbx_sync #(.STAGES(SYNC_DEPTH)) u_put_sync (
        .clk (rclk),
        .rst_n(rst_n),
        .d   (w_tog),
        .q   (put_sync)
    );

    mbx_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
        .clk (wclk),
        .rst_n(rst_n),
        .d   (r_tog),
        .q   (ack_sync)
    );

    // writer state register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            w_state <= W_EMPTY;
            w_tog   <= 1'b0;
            data_q  <= '0;
        end else begin
            w_state <= w_next;
            if (w_load) begin
                w_tog  <= ~w_tog;
                data_q <= wdata;
            end
        end
    end

    // writer next state and outputs
    always_comb begin
        w_next = w_state;
        w_load = 1'b0;
        unique case (w_state)
            W_EMPTY: begin
                if (wr_req) begin
                    w_next = W_FULL;
                    w_load = 1'b1;
                end
            end
            W_FULL: begin
                if (ack_sync == w_tog) w_next = W_EMPTY;
            end
            default: w_next = W_EMPTY;
        endcase
    end

    assign full_n = (w_state == W_EMPTY);

    // reader state register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            r_state <= R_IDLE;
            r_tog   <= 1'b0;
        end else begin
            r_state <= r_next;
            if (r_ack) r_tog <= ~r_tog;
        end
    end

    // reader next state and outputs
    always_comb begin
        r_next = r_state;
        r_ack  = 1'b0;
        unique case (r_state)
            R_IDLE: begin
                if (put_sync != r_tog) r_next = R_HOLD;
            end
            R_HOLD: begin
                if (rd_req) begin
                    r_next = R_IDLE;
                    r_ack  = 1'b1;
                end
            end
            default: r_next = R_IDLE;
        endcase
    end

    assign ready = (r_state == R_HOLD);
    assign rdata = data_q;

    AST_WRITE_LOADS: assert property (@(posedge wclk) disable iff (!rst_n)
        (full_n && wr_req) |=> (!full_n && data_q == $past(wdata))); // R1

    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && wr_req) |=> $stable(data_q)); // R2

    AST_READ_RELEASES: assert property (@(posedge rclk) disable iff (!rst_n)
        (ready && rd_req) |=> !ready); // R3

    AST_IDLE_READ_NOP: assert property (@(posedge rclk) disable iff (!rst_n)
        (!ready && rd_req) |=> $stable(r_tog)); // R4
endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int W           = MBX_W,
    parameter bit WRITE_LEVEL = 1'b1
) (
    input  logic         wr_sel,
    input  logic         mbx_sel,
    input  logic [W-1:0] mbx_in,
    input  logic [W-1:0] fifo_q,
    output logic         mbx_wr,
    output logic         mbx_rd,
    output logic         oe,
    output logic [W-1:0] rdata
);
    logic is_write;

    generate
        if (WRITE_LEVEL) begin : g_write_high
            assign is_write = wr_sel;
        end else begin : g_write_low
            assign is_write = ~wr_sel;
        end
    endgenerate

    assign mbx_wr = is_write & mbx_sel;
    assign mbx_rd = ~is_write & mbx_sel;
    assign oe     = ~is_write;
    assign rdata  = mbx_sel ? mbx_in : fifo_q;

    always_comb begin
        AST_OE_OFF_ON_WRITE: assert (!(mbx_wr && oe)); // R5
    end
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int W          = MBX_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         fifo1_rst_n,
    input  logic         fifo2_rst_n,
    input  logic         a_wr_sel,
    input  logic         a_mbx_sel,
    input  logic [W-1:0] a_wdata,
    input  logic [W-1:0] a_fifo_q,
    output logic [W-1:0] a_rdata,
    output logic         a_oe,
    output logic         a_mail_full_n,
    output logic         a_mail_ready,
    input  logic         b_wr_sel,
    input  logic         b_mbx_sel,
    input  logic [W-1:0] b_wdata,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_rdata,
    output logic         b_oe,
    output logic         b_mail_full_n,
    output logic         b_mail_ready
);
    logic         a_wr, a_rd, b_wr, b_rd;
    logic [W-1:0] mail1_q, mail2_q;

    mbx_port #(.W(W), .WRITE_LEVEL(1'b1)) u_port_a (
        .wr_sel (a_wr_sel),
        .mbx_sel(a_mbx_sel),
        .mbx_in (mail2_q),
        .fifo_q (a_fifo_q),
        .mbx_wr (a_wr),
        .mbx_rd (a_rd),
        .oe     (a_oe),
        .rdata  (a_rdata)
    );

    mbx_port #(.W(W), .WRITE_LEVEL(1'b0)) u_port_b (
        .wr_sel (b_wr_sel),
        .mbx_sel(b_mbx_sel),
        .mbx_in (mail1_q),
        .fifo_q (b_fifo_q),
        .mbx_wr (b_wr),
        .mbx_rd (b_rd),
        .oe     (b_oe),
        .rdata  (b_rdata)
    );

    // mailbox 1: written on port A, read on port B
    mbx_slot #(.W(W), .SYNC_DEPTH(SYNC_DEPTH)) u_mail1 (
        .wclk  (clk_a),
        .rclk  (clk_b),
        .rst_n (fifo1_rst_n),
        .wr_req(a_wr),
        .wdata (a_wdata),
        .full_n(a_mail_full_n),
        .rd_req(b_rd),
        .ready (b_mail_ready),
        .rdata (mail1_q)
    );

    // mailbox 2: written on port B, read on port A
    mbx_slot #(.W(W), .SYNC_DEPTH(SYNC_DEPTH)) u_mail2 (
        .wclk  (clk_b),
        .rclk  (clk_a),
        .rst_n (fifo2_rst_n),
        .wr_req(b_wr),
        .wdata (b_wdata),
        .full_n(b_mail_full_n),
        .rd_req(a_rd),
        .ready (a_mail_ready),
        .rdata (mail2_q)
    );
endmodule

// File: tb/mbx_pair_tb.sv
`timescale 1ns/100ps
module mbx_pair_tb;
    localparam int W = 36;
    localparam int NMSG = 40;

    logic clk_a = 0, clk_b = 0;
    logic fifo1_rst_n = 0, fifo2_rst_n = 0;
    logic a_wr_sel = 0, a_mbx_sel = 0, b_wr_sel = 1, b_mbx_sel = 0;
    logic [W-1:0] a_wdata = '0, a_fifo_q = '0, b_wdata = '0, b_fifo_q = '0;
    logic [W-1:0] a_rdata, b_rdata;
    logic a_oe, b_oe, a_mail_full_n, a_mail_ready, b_mail_full_n, b_mail_ready;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #10   clk_a = ~clk_a;
    always #16.5 clk_b = ~clk_b;

    mbx_pair u_dut (.*);

    function automatic logic [W-1:0] pat(int i, int dir);
        return (36'h5_A5A0_3C3C ^ (36'(i) * 36'h9_E377)) ^ (36'(dir) << 34);
    endfunction

    task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk_a) begin
        cyc++;
        if (cyc == 100000) begin
            n_tests++; n_fail++;
            $display("FAIL R8 watchdog actual=%0d expected=<100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic wait_b_ready();
        for (int k = 0; k < 20 && !b_mail_ready; k++) @(negedge clk_b);
    endtask
    task automatic wait_a_ready();
        for (int k = 0; k < 30 && !a_mail_ready; k++) @(negedge clk_a);
    endtask
    task automatic wait_a_flag();
        for (int k = 0; k < 30 && !a_mail_full_n; k++) @(negedge clk_a);
    endtask
    task automatic wait_b_flag();
        for (int k = 0; k < 20 && !b_mail_full_n; k++) @(negedge clk_b);
    endtask

    task automatic a_write1(logic [W-1:0] d);
        @(negedge clk_a); a_wr_sel = 1; a_mbx_sel = 1; a_wdata = d;
        @(negedge clk_a); a_mbx_sel = 0;
    endtask

    task automatic b_read1();
        @(negedge clk_b); b_wr_sel = 1; b_mbx_sel = 1;
        @(negedge clk_b); b_mbx_sel = 0;
    endtask

    task automatic a_producer();
        for (int i = 0; i < NMSG; i++) begin
            @(negedge clk_a);
            while (!a_mail_full_n) @(negedge clk_a);
            a_wr_sel = 1; a_mbx_sel = 1; a_wdata = pat(i, 1);
            @(negedge clk_a); a_mbx_sel = 0;
            repeat ($urandom % 4) @(negedge clk_a);
        end
    endtask

    task automatic b_consumer();
        int idx = 0;
        while (idx < NMSG) begin
            @(negedge clk_b);
            if ($urandom % 3 == 0) begin b_mbx_sel = 0; continue; end
            b_wr_sel = 1; b_mbx_sel = 1;
            #1;
            if (b_mail_ready) begin
                chk(b_rdata == pat(idx, 1), "R8 mail1 order", b_rdata, pat(idx, 1));
                idx++;
            end
        end
        @(negedge clk_b); b_mbx_sel = 0;
    endtask

    task automatic b_producer();
        for (int i = 0; i < NMSG; i++) begin
            @(negedge clk_b);
            while (!b_mail_full_n) @(negedge clk_b);
            b_wr_sel = 0; b_mbx_sel = 1; b_wdata = pat(i, 2);
            @(negedge clk_b); b_mbx_sel = 0;
            repeat ($urandom % 3) @(negedge clk_b);
        end
    endtask

    task automatic a_consumer();
        int idx = 0;
        while (idx < NMSG) begin
            @(negedge clk_a);
            if ($urandom % 2 == 0) begin a_mbx_sel = 0; continue; end
            a_wr_sel = 0; a_mbx_sel = 1;
            #1;
            if (a_mail_ready) begin
                chk(a_rdata == pat(idx, 2), "R8 mail2 order", a_rdata, pat(idx, 2));
                idx++;
            end
        end
        @(negedge clk_a); a_mbx_sel = 0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk_a);
        fifo1_rst_n = 1; fifo2_rst_n = 1;
        @(negedge clk_a);

        // reset state
        chk(a_mail_full_n == 1, "R7 reset flag1", 36'(a_mail_full_n), 36'd1);
        chk(b_mail_full_n == 1, "R7 reset flag2", 36'(b_mail_full_n), 36'd1);
        chk(!a_mail_ready && !b_mail_ready, "R7 reset ready", 36'({a_mail_ready, b_mail_ready}), 36'd0);

        // R5 polarity and R6 mux
        a_wr_sel = 1; #1; chk(a_oe == 0, "R5 a write hiZ", 36'(a_oe), 36'd0);
        a_wr_sel = 0; a_mbx_sel = 0; a_fifo_q = 36'hA_1234_5678; #1;
        chk(a_oe == 1, "R5 a read drive", 36'(a_oe), 36'd1);
        chk(a_rdata == 36'hA_1234_5678, "R6 a fifo path", a_rdata, 36'hA_1234_5678);
        b_wr_sel = 0; #1; chk(b_oe == 0, "R5 b write hiZ", 36'(b_oe), 36'd0);
        b_wr_sel = 1; b_fifo_q = 36'h3_8765_4321; #1;
        chk(b_oe == 1, "R5 b read drive", 36'(b_oe), 36'd1);
        chk(b_rdata == 36'h3_8765_4321, "R6 b fifo path", b_rdata, 36'h3_8765_4321);

        // R1: write with mailbox select low is not a mailbox write
        @(negedge clk_a); a_wr_sel = 1; a_mbx_sel = 0; a_wdata = 36'h1;
        @(negedge clk_a);
        chk(a_mail_full_n == 1, "R1 sel low no write", 36'(a_mail_full_n), 36'd1);

        // R1, R2: write, then a blocked second write
        a_write1(36'h1_1111_1111);
        chk(a_mail_full_n == 0, "R1 flag1 low", 36'(a_mail_full_n), 36'd0);
        a_write1(36'h2_2222_2222);
        wait_b_ready();
        chk(b_mail_ready == 1, "R3 ready rises", 36'(b_mail_ready), 36'd1);
        b_wr_sel = 1; b_mbx_sel = 1; #1;
        chk(b_rdata == 36'h1_1111_1111, "R2 R6 first word kept", b_rdata, 36'h1_1111_1111);
        @(negedge clk_b); b_mbx_sel = 0;
        chk(b_mail_ready == 0, "R3 ready clears", 36'(b_mail_ready), 36'd0);
        wait_a_flag();
        chk(a_mail_full_n == 1, "R3 flag1 released", 36'(a_mail_full_n), 36'd1);

        // R4: reads with no mail have no effect
        repeat (4) b_read1();
        @(negedge clk_a);
        chk(a_mail_full_n == 1 && !b_mail_ready, "R4 idle read", 36'({a_mail_full_n, b_mail_ready}), 36'h2);
        a_write1(36'h4_4444_4444);
        repeat (12) @(negedge clk_a);
        chk(a_mail_full_n == 0, "R4 flag stays low", 36'(a_mail_full_n), 36'd0);
        wait_b_ready();
        b_read1();
        wait_a_flag();
        chk(a_mail_full_n == 1, "R4 later read releases", 36'(a_mail_full_n), 36'd1);

        // R1 for port B, read by port A
        @(negedge clk_b); b_wr_sel = 0; b_mbx_sel = 1; b_wdata = 36'h7_7777_0001;
        @(negedge clk_b); b_mbx_sel = 0; b_wr_sel = 1;
        chk(b_mail_full_n == 0, "R1 flag2 low", 36'(b_mail_full_n), 36'd0);
        wait_a_ready();
        a_wr_sel = 0; a_mbx_sel = 1; #1;
        chk(a_rdata == 36'h7_7777_0001, "R6 a mailbox path", a_rdata, 36'h7_7777_0001);
        @(negedge clk_a); a_mbx_sel = 0;
        wait_b_flag();
        chk(b_mail_full_n == 1, "R3 flag2 released", 36'(b_mail_full_n), 36'd1);

        // R7: resets with mail pending, and isolation
        a_write1(36'h9_0000_0009);
        wait_b_ready();
        @(negedge clk_a); fifo2_rst_n = 0;
        repeat (4) @(negedge clk_a); fifo2_rst_n = 1;
        @(negedge clk_a);
        chk(a_mail_full_n == 0 && b_mail_ready, "R7 fifo2 reset isolation", 36'({a_mail_full_n, b_mail_ready}), 36'h1);
        fifo1_rst_n = 0;
        repeat (4) @(negedge clk_b); fifo1_rst_n = 1;
        @(negedge clk_a);
        chk(a_mail_full_n == 1, "R7 fifo1 reset flag", 36'(a_mail_full_n), 36'd1);
        chk(b_mail_ready == 0, "R7 fifo1 reset ready", 36'(b_mail_ready), 36'd0);

        // R8: random traffic both directions
        fork
            a_producer();
            b_consumer();
        join
        fork
            b_producer();
            a_consumer();
        join
        repeat (10) @(negedge clk_a);
        chk(a_mail_full_n && b_mail_full_n, "R8 all released", 36'({a_mail_full_n, b_mail_full_n}), 36'h3);
        finish_run();
    end
endmodule